// File: doc/BRIEF.md
# Endian-Selectable Bus-Matching Width Converter

This block sits between a FIFO that stores only full 36-bit words and a narrower external port. The port is configured as a full long-word bus, an 18-bit half-word bus or a 9-bit byte bus. On the read side, each word taken from the FIFO is handed out as one, two or four port transfers. On the write side, one, two or four port transfers are gathered and then sent to the FIFO as a single word.

A byte-order input selects the order of segments. When it is high, the most significant segment goes first; when it is low, the least significant segment goes first. Bus size and byte order are taken once, on the first clock edge after reset is released. Both ready outputs stay low until that capture has happened. After that, both settings are frozen until the next reset. Mailbox traffic does not pass through this block.

Top module: `bus_match_conv`

## Requirements
- R1: On the first rising clock edge after rst_ni goes high, size_sel_i and msb_first_i are captured, and both fifo_rd_ready_o and port_wr_ready_o stay low until that edge. After the capture, changes on either input have no effect until the next reset.
- R2: size_sel_i = 2'b00 selects long-word mode. Each word moves in a single transfer on all 36 bits in both directions, and msb_first_i has no effect.
- R3: size_sel_i = 2'b01 selects half-word mode on the read side. Each word gives two transfers on port_rd_data_o[17:0], with bits 35:18 driven to zero. Bits 17:0 of the word go first when msb_first is low; bits 35:18 go first when it is high.
- R4: size_sel_i = 2'b10 or 2'b11 selects byte mode on the read side. Each word gives four transfers on port_rd_data_o[8:0], with the upper bits zero. The order is lanes 0,1,2,3 (lane n = bits 9n+8:9n) when msb_first is low, and 3,2,1,0 when it is high.
- R5: fifo_rd_ready_o is high only when no segment of the current word is still pending. It returns high right after the last segment is taken with port_rd_en_i.
- R6: While port_rd_valid_o is high and port_rd_en_i is low, port_rd_data_o and port_rd_valid_o hold their values.
- R7: In half-word mode, the write side takes port_wr_data_i[17:0] on each accepted transfer and ignores bits 35:18. The first transfer fills the low half when msb_first is low, and the high half when it is high.
- R8: In byte mode, the write side takes port_wr_data_i[8:0] on each accepted transfer and ignores the upper bits. The transfers fill lanes 0..3 when msb_first is low and lanes 3..0 when it is high.
- R9: fifo_wr_valid_o rises only after the final transfer of a group is accepted. The word is held stable until fifo_wr_ready_i is high, and port_wr_ready_o is low while the word waits.
- R10: Reset discards a partly assembled write group, so the next accepted transfer starts a new group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| size_sel_i | input | 2 | Port size: 00 long, 01 half, 1x byte |
| msb_first_i | input | 1 | Segment order: 1 = most significant first |
| fifo_rd_data_i | input | 36 | Word from FIFO |
| fifo_rd_valid_i | input | 1 | FIFO word available |
| fifo_rd_ready_o | output | 1 | Converter takes a FIFO word |
| port_rd_data_o | output | 36 | Read segment, right aligned |
| port_rd_valid_o | output | 1 | Read segment pending |
| port_rd_en_i | input | 1 | Port takes current read segment |
| port_wr_data_i | input | 36 | Write segment, right aligned |
| port_wr_en_i | input | 1 | Port presents a write segment |
| port_wr_ready_o | output | 1 | Converter accepts a write segment |
| fifo_wr_data_o | output | 36 | Packed word to FIFO |
| fifo_wr_valid_o | output | 1 | Packed word ready |
| fifo_wr_ready_i | input | 1 | FIFO accepts the word |

## Verification
Some properties are checked on every cycle:
- the configuration stays frozen once captured;
- both ready outputs stay low before capture;
- a pending read segment does not move without a strobe;
- a fetched word always leads to a pending segment, and the last strobe releases it;
- a packed word stays steady under FIFO backpressure, and it only appears right after an accepted port transfer.

Other behaviour can only be shown by the bench's scenarios, because it needs data compared against an independent model:
- the segment order and lane placement for each size and byte order;
- the masking of unused upper port bits;
- that inputs changed after capture have no effect;
- that a half-built group is lost on reset.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [1:0] {
    BM_LONG = 2'b00,
    BM_HALF = 2'b01,
    BM_BYTE = 2'b10
  } bm_size_e;

  typedef struct packed {
    bm_size_e size;
    logic     msb_first;
  } bm_cfg_t;

  function automatic bm_size_e decode_size(logic [1:0] sel);
    if (sel == 2'b00)      return BM_LONG;
    else if (sel == 2'b01) return BM_HALF;
    else                   return BM_BYTE;
  endfunction

  function automatic logic [1:0] last_seg(bm_size_e s);
    case (s)
      BM_HALF: return 2'd1;
      BM_BYTE: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/bm_cfg.sv
module bm_cfg
  import bm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] size_sel_i,
  input  logic       msb_first_i,
  output bm_cfg_t    cfg_o,
  output logic       cfg_vld_o
);
  bm_cfg_t cfg_q;
  logic    vld_q;

  // capture once, on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{size: BM_LONG, msb_first: 1'b0};
      vld_q <= 1'b0;
    end else if (!vld_q) begin
      cfg_q <= '{size: decode_size(size_sel_i), msb_first: msb_first_i};
      vld_q <= 1'b1;
    end
  end

  assign cfg_o     = cfg_q;
  assign cfg_vld_o = vld_q;

  p_cfg_frozen_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |=> vld_q && $stable(cfg_q));
endmodule

// File: rtl/bm_unpack.sv
module bm_unpack
  import bm_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bm_cfg_t           cfg_i,
  input  logic              cfg_vld_i,
  input  logic [WORD_W-1:0] fifo_data_i,
  input  logic              fifo_valid_i,
  output logic              fifo_ready_o,
  output logic [WORD_W-1:0] prt_data_o,
  output logic              prt_valid_o,
  input  logic              prt_en_i
);
  localparam int HALF_W = WORD_W / 2;
  localparam int QTR_W  = WORD_W / 4;

  logic [WORD_W-1:0] hold_q;
  logic              hold_vld_q;
  logic [1:0]        cnt_q, last, idx;
  logic              take, fetch;
  logic [HALF_W-1:0] half_lane [2];
  logic [QTR_W-1:0]  qtr_lane  [4];

  for (genvar g = 0; g < 2; g++) begin : g_half
    assign half_lane[g] = hold_q[g*HALF_W +: HALF_W];
  end
  for (genvar g = 0; g < 4; g++) begin : g_qtr
    assign qtr_lane[g] = hold_q[g*QTR_W +: QTR_W];
  end

  assign last         = last_seg(cfg_i.size);
  assign idx          = cfg_i.msb_first ? last - cnt_q : cnt_q;
  assign fifo_ready_o = cfg_vld_i & ~hold_vld_q;
  assign fetch        = fifo_valid_i & fifo_ready_o;
  assign take         = prt_en_i & hold_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
      cnt_q      <= '0;
    end else if (fetch) begin
      hold_q     <= fifo_data_i;
      hold_vld_q <= 1'b1;
      cnt_q      <= '0;
    end else if (take) begin
      if (cnt_q == last) begin
        hold_vld_q <= 1'b0;
        cnt_q      <= '0;
      end else begin
        cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  always_comb begin
    case (cfg_i.size)
      BM_HALF: prt_data_o = WORD_W'(half_lane[idx[0]]);
      BM_BYTE: prt_data_o = WORD_W'(qtr_lane[idx]);
      default: prt_data_o = hold_q;
    endcase
  end

  assign prt_valid_o = hold_vld_q;

  p_fetch_fills_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_valid_i && fifo_ready_o |=> prt_valid_o);
  p_last_frees_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prt_valid_o && prt_en_i && (cnt_q == last) |=> !prt_valid_o && fifo_ready_o);
  p_seg_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prt_valid_o && !prt_en_i |=> prt_valid_o && $stable(prt_data_o));
endmodule

// File: rtl/bm_pack.sv
module bm_pack
  import bm_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bm_cfg_t           cfg_i,
  input  logic              cfg_vld_i,
  input  logic [WORD_W-1:0] prt_data_i,
  input  logic              prt_en_i,
  output logic              prt_ready_o,
  output logic [WORD_W-1:0] fifo_data_o,
  output logic              fifo_valid_o,
  input  logic              fifo_ready_i
);
  localparam int HALF_W = WORD_W / 2;
  localparam int QTR_W  = WORD_W / 4;

  logic [WORD_W-1:0] acc_q, acc_nxt;
  logic              full_q;
  logic [1:0]        cnt_q, last, idx;
  logic              put;

  assign last        = last_seg(cfg_i.size);
  assign idx         = cfg_i.msb_first ? last - cnt_q : cnt_q;
  assign prt_ready_o = cfg_vld_i & ~full_q;
  assign put         = prt_en_i & prt_ready_o;

  always_comb begin
    acc_nxt = acc_q;
    case (cfg_i.size)
      BM_HALF: begin
        for (int g = 0; g < 2; g++)
          if (idx[0] == 1'(g)) acc_nxt[g*HALF_W +: HALF_W] = prt_data_i[HALF_W-1:0];
      end
      BM_BYTE: begin
        for (int g = 0; g < 4; g++)
          if (idx == 2'(g)) acc_nxt[g*QTR_W +: QTR_W] = prt_data_i[QTR_W-1:0];
      end
      default: acc_nxt = prt_data_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      full_q <= 1'b0;
      cnt_q  <= '0;
    end else if (put) begin
      acc_q <= acc_nxt;
      if (cnt_q == last) begin
        cnt_q  <= '0;
        full_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 2'd1;
      end
    end else if (full_q && fifo_ready_i) begin
      full_q <= 1'b0;
    end
  end

  assign fifo_data_o  = acc_q;
  assign fifo_valid_o = full_q;

  p_word_after_put_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fifo_valid_o) |-> $past(put));
  p_word_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_valid_o && !fifo_ready_i |=> fifo_valid_o && $stable(fifo_data_o));
  p_no_put_while_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_valid_o |-> !prt_ready_o);
endmodule

// File: rtl/bus_match_conv.sv
module bus_match_conv
  import bm_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        size_sel_i,
  input  logic              msb_first_i,
  input  logic [WORD_W-1:0] fifo_rd_data_i,
  input  logic              fifo_rd_valid_i,
  output logic              fifo_rd_ready_o,
  output logic [WORD_W-1:0] port_rd_data_o,
  output logic              port_rd_valid_o,
  input  logic              port_rd_en_i,
  input  logic [WORD_W-1:0] port_wr_data_i,
  input  logic              port_wr_en_i,
  output logic              port_wr_ready_o,
  output logic [WORD_W-1:0] fifo_wr_data_o,
  output logic              fifo_wr_valid_o,
  input  logic              fifo_wr_ready_i
);
  bm_cfg_t cfg;
  logic    cfg_vld;

  bm_cfg i_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .size_sel_i  (size_sel_i),
    .msb_first_i (msb_first_i),
    .cfg_o       (cfg),
    .cfg_vld_o   (cfg_vld)
  );

  bm_unpack #(.WORD_W(WORD_W)) i_unpack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_i        (cfg),
    .cfg_vld_i    (cfg_vld),
    .fifo_data_i  (fifo_rd_data_i),
    .fifo_valid_i (fifo_rd_valid_i),
    .fifo_ready_o (fifo_rd_ready_o),
    .prt_data_o   (port_rd_data_o),
    .prt_valid_o  (port_rd_valid_o),
    .prt_en_i     (port_rd_en_i)
  );

  bm_pack #(.WORD_W(WORD_W)) i_pack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_i        (cfg),
    .cfg_vld_i    (cfg_vld),
    .prt_data_i   (port_wr_data_i),
    .prt_en_i     (port_wr_en_i),
    .prt_ready_o  (port_wr_ready_o),
    .fifo_data_o  (fifo_wr_data_o),
    .fifo_valid_o (fifo_wr_valid_o),
    .fifo_ready_i (fifo_wr_ready_i)
  );

  p_idle_until_cfg_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_vld |-> !fifo_rd_ready_o && !port_wr_ready_o);
endmodule

// File: tb/test_bus_match_conv.sv
`timescale 1ns/1ps
module test_bus_match_conv;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  size_sel_i = 2'b00;
  logic        msb_first_i = 1'b0;
  logic [35:0] fifo_rd_data_i = '0;
  logic        fifo_rd_valid_i = 1'b0;
  logic        fifo_rd_ready_o;
  logic [35:0] port_rd_data_o;
  logic        port_rd_valid_o;
  logic        port_rd_en_i = 1'b0;
  logic [35:0] port_wr_data_i = '0;
  logic        port_wr_en_i = 1'b0;
  logic        port_wr_ready_o;
  logic [35:0] fifo_wr_data_o;
  logic        fifo_wr_valid_o;
  logic        fifo_wr_ready_i = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int cur_mode = 0;  // 0 long, 1 half, 2 byte
  bit cur_big  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bus_match_conv i_bus_match_conv (.*);

  task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int seg_n(int mode);
    return (mode == 0) ? 1 : (mode == 1) ? 2 : 4;
  endfunction

  function automatic logic [35:0] seg_mask(int mode);
    int wd = 36 / seg_n(mode);
    return (36'd1 << wd) - 36'd1;
  endfunction

  function automatic logic [35:0] exp_rd_seg(logic [35:0] w, int mode, bit big, int k);
    int n = seg_n(mode);
    int idx = big ? n - 1 - k : k;
    int wd = 36 / n;
    return (w >> (idx * wd)) & seg_mask(mode);
  endfunction

  function automatic logic [35:0] exp_packed(logic [35:0] s0, logic [35:0] s1, logic [35:0] s2,
                                             logic [35:0] s3, int mode, bit big);
    logic [35:0] segs [4];
    logic [35:0] w = '0;
    int n = seg_n(mode);
    int wd = 36 / n;
    segs[0] = s0; segs[1] = s1; segs[2] = s2; segs[3] = s3;
    for (int k = 0; k < n; k++) begin
      int idx = big ? n - 1 - k : k;
      w |= (segs[k] & seg_mask(mode)) << (idx * wd);
    end
    return w;
  endfunction

  function automatic string rd_req(int mode);
    return (mode == 0) ? "R2" : (mode == 1) ? "R3" : "R4";
  endfunction

  function automatic string wr_req(int mode);
    return (mode == 0) ? "R2" : (mode == 1) ? "R7" : "R8";
  endfunction

  task automatic do_reset(input int mode, input bit big);
    @(negedge clk_i);
    rst_ni = 1'b0;
    port_rd_en_i = 1'b0; port_wr_en_i = 1'b0;
    fifo_rd_valid_i = 1'b0; fifo_wr_ready_i = 1'b0;
    size_sel_i = (mode == 0) ? 2'b00 : (mode == 1) ? 2'b01 : ($urandom % 2 ? 2'b11 : 2'b10);
    msb_first_i = big;
    cur_mode = mode; cur_big = big;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    #0.1;
    check(!fifo_rd_ready_o && !port_wr_ready_o, "R1 ready before capture",
          {34'd0, fifo_rd_ready_o, port_wr_ready_o}, 36'd0);
    @(negedge clk_i);
    check(fifo_rd_ready_o && port_wr_ready_o, "R1 ready after capture",
          {34'd0, fifo_rd_ready_o, port_wr_ready_o}, 36'd3);
    // scramble config inputs: must have no effect now
    size_sel_i = 2'($urandom);
    msb_first_i = 1'($urandom);
  endtask

  task automatic rd_word(input logic [35:0] w, input bit stall);
    int n = seg_n(cur_mode);
    fifo_rd_valid_i = 1'b1;
    fifo_rd_data_i = w;
    while (!fifo_rd_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    fifo_rd_valid_i = 1'b0;
    fifo_rd_data_i = 36'($urandom);
    for (int k = 0; k < n; k++) begin
      logic [35:0] e = exp_rd_seg(w, cur_mode, cur_big, k);
      if (stall && ($urandom % 2)) begin
        port_rd_en_i = 1'b0;
        repeat (1 + $urandom % 2) begin
          @(negedge clk_i);
          check(port_rd_valid_o && port_rd_data_o == e, "R6 segment hold", port_rd_data_o, e);
          check(!fifo_rd_ready_o, "R5 no fetch while pending", {35'd0, fifo_rd_ready_o}, 36'd0);
        end
      end
      check(port_rd_valid_o && port_rd_data_o == e, rd_req(cur_mode), port_rd_data_o, e);
      port_rd_en_i = 1'b1;
      @(negedge clk_i);
    end
    port_rd_en_i = 1'b0;
    check(fifo_rd_ready_o && !port_rd_valid_o, "R5 ready after last segment",
          {34'd0, fifo_rd_ready_o, port_rd_valid_o}, 36'd2);
  endtask

  task automatic wr_word(input logic [35:0] s0, input logic [35:0] s1, input logic [35:0] s2,
                         input logic [35:0] s3);
    logic [35:0] segs [4];
    logic [35:0] e = exp_packed(s0, s1, s2, s3, cur_mode, cur_big);
    int n = seg_n(cur_mode);
    segs[0] = s0; segs[1] = s1; segs[2] = s2; segs[3] = s3;
    for (int k = 0; k < n; k++) begin
      check(port_wr_ready_o && !fifo_wr_valid_o, "R9 no word before final segment",
            {34'd0, port_wr_ready_o, fifo_wr_valid_o}, 36'd2);
      port_wr_en_i = 1'b1;
      port_wr_data_i = segs[k];
      @(negedge clk_i);
    end
    port_wr_en_i = 1'b0;
    port_wr_data_i = 36'($urandom);
    check(fifo_wr_valid_o && fifo_wr_data_o == e, wr_req(cur_mode), fifo_wr_data_o, e);
    repeat ($urandom % 3) begin
      @(negedge clk_i);
      check(fifo_wr_valid_o && !port_wr_ready_o && fifo_wr_data_o == e, "R9 word hold",
            fifo_wr_data_o, e);
    end
    fifo_wr_ready_i = 1'b1;
    @(negedge clk_i);
    fifo_wr_ready_i = 1'b0;
    check(!fifo_wr_valid_o && port_wr_ready_o, "R9 word released",
          {34'd0, fifo_wr_valid_o, port_wr_ready_o}, 36'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // directed corners: known patterns per mode and order (R2, R3, R4, R7, R8)
    for (int m = 0; m < 3; m++) begin
      for (int b = 0; b < 2; b++) begin
        do_reset(m, 1'(b));
        rd_word(36'h123456789, 1'b0);
        wr_word(36'hF_FFFF_F0A5, 36'hA_AAAA_A15A, 36'h5_5555_50C3, 36'h0_0000_013C);
        // random traffic with stalls and garbage upper bits
        for (int i = 0; i < 6; i++) begin
          rd_word({4'($urandom), 32'($urandom)}, 1'b1);
          wr_word({4'($urandom), 32'($urandom)}, {4'($urandom), 32'($urandom)},
                  {4'($urandom), 32'($urandom)}, {4'($urandom), 32'($urandom)});
        end
      end
    end
    // R10: half-built byte group dropped by reset
    do_reset(2, 1'b0);
    for (int k = 0; k < 2; k++) begin
      port_wr_en_i = 1'b1;
      port_wr_data_i = 36'h1FF;
      @(negedge clk_i);
    end
    port_wr_en_i = 1'b0;
    do_reset(2, 1'b0);
    check(!fifo_wr_valid_o, "R10 no stale word after reset", {35'd0, fifo_wr_valid_o}, 36'd0);
    wr_word(36'h011, 36'h022, 36'h033, 36'h044);
    // R1: config frozen while inputs toggle (half, big-endian captured)
    do_reset(1, 1'b1);
    size_sel_i = 2'b10; msb_first_i = 1'b0;
    rd_word(36'hABCDE_1234, 1'b0);
    size_sel_i = 2'b00;
    wr_word(36'h3_0000, 36'h2_BEEF, 36'h0, 36'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule